// File: doc/BRIEF.md
# Serial-In Shift Register with Parallel Output Latch

This block takes a serial bit stream into a chain of shift stages and holds a snapshot of that chain in a separate output latch. Both registers sit in one system clock domain. A shift strobe advances the chain by one position, and a store strobe copies the chain into the latch. The two strobes are independent, so software or a sequencer can shift a full word in while the latch keeps showing the previous word, then update every parallel output at once.

The latched word leaves the block as a data bus qualified by a valid flag. An active-low output enable drives that flag. The last shift stage is exposed as a serial output, so several copies can be chained into a longer register. An active-low asynchronous clear empties only the shift chain. A system reset zeroes both registers. The width and the value the bus shows while disabled are set by parameters.

Top module: `sipo_latch_reg`

## Requirements
- R1: While `rst_n` is low, every shift stage and the latch are zero, so `ser_out` is 0 and `par_data` is all zeros.
- R2: On a clock edge with `shift_en` high and `clr_n` high, stage 0 takes `ser_in` and each stage k (k ≥ 1) takes the old value of stage k-1. With `shift_en` low, the chain holds.
- R3: `ser_out` always equals the highest shift stage (WIDTH-1). It does not depend on the latch, on `store_en` or on `oe_n`.
- R4: On a clock edge with `store_en` high, latch bit k takes shift stage k, for all bits at once. With `store_en` low, the latch holds.
- R5: When `shift_en` and `store_en` are high in the same cycle, the latch receives the chain contents from before that cycle's shift.
- R6: While `clr_n` is low, all shift stages read 0 at once, without waiting for a clock edge, and `shift_en` has no effect. The latch and `par_data` keep their value.
- R7: A store taken while `clr_n` is low loads an all-zero word into the latch.
- R8: While `oe_n` is low, `par_valid` is 1 and `par_data` equals the latch. While `oe_n` is high, `par_valid` is 0. With the default `OFF_ZERO` mode, `par_data` is then all zeros. Neither value of `oe_n` changes either register.
- R9: With two blocks cascaded (near `ser_out` into far `ser_in`, strobes shared), 16 shifts followed by one store leave the first 8 bits on the far block and the last 8 on the near block. The first bit shifted in appears on far `par_data[7]`, and the last bit shifted in appears on near `par_data[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of chain and latch |
| clr_n | input | 1 | Asynchronous active-low clear of the shift chain only |
| ser_in | input | 1 | Serial data into stage 0 |
| shift_en | input | 1 | Advance the chain by one stage this cycle |
| store_en | input | 1 | Copy the chain into the latch this cycle |
| oe_n | input | 1 | Active-low enable of the parallel outputs |
| par_data | output | WIDTH | Latched word, bit k from stage k |
| par_valid | output | 1 | High while the parallel outputs are enabled |
| ser_out | output | 1 | Highest shift stage, used for cascading |

## Verification
A shift and a store can fall in the same edge. A clear and a store can also coincide, with the clear held low across the edge. The bench provokes both with directed steps and again with random strobe patterns. A same-edge shift and store is judged correct only if the latch shows the chain from before that shift. A clear held across a store is judged correct only if the latch shows zero. A bench model that applies the store before the shift produces the expected words.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
   // Value presented on the parallel bus while the outputs are disabled
   typedef enum logic {
      OFF_ZERO = 1'b0,   // bus forced to zero
      OFF_HOLD = 1'b1    // bus keeps showing the latch, only valid drops
   } off_mode_e;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_n,
   input  logic             shift_en,
   input  logic             ser_in,
   output logic [WIDTH-1:0] stages
);
   localparam int TOP = WIDTH - 1;

   logic             arst_n;
   logic [WIDTH-1:0] nxt;

   assign arst_n = rst_n & clr_n;

   // Per-stage input selection
   for (genvar k = 0; k < WIDTH; k++) begin : g_stage
      if (k == 0) begin : g_head
         assign nxt[k] = ser_in;
      end else begin : g_body
         assign nxt[k] = stages[k-1];
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)       stages <= '0;
      else if (shift_en) stages <= nxt;
   end

   // R2: one-position advance with the new bit at stage 0
   assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      shift_en |=> (stages == {$past(stages[TOP-1:0]), $past(ser_in)}));

   // R2: chain holds without a strobe
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      !shift_en |=> $stable(stages));

   // R6: clear empties every stage
   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (stages == '0));
endmodule

// File: rtl/sipo_store_reg.sv
module sipo_store_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             store_en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (store_en) q <= d;
   end

   // R4: parallel capture of the chain
   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      store_en |=> (q == $past(d)));

   // R4: latch holds without a strobe
   assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !store_en |=> $stable(q));
endmodule

// File: rtl/sipo_out_drive.sv
module sipo_out_drive
   import sipo_pkg::*;
#(
   parameter int        WIDTH    = 8,
   parameter off_mode_e OFF_MODE = OFF_ZERO
) (
   input  logic             oe_n,
   input  logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] data,
   output logic             valid
);
   assign valid = ~oe_n;

   if (OFF_MODE == OFF_ZERO) begin : g_mask
      assign data = oe_n ? '0 : latch_q;
   end else begin : g_pass
      assign data = latch_q;
   end
endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg
   import sipo_pkg::*;
#(
   parameter int        WIDTH    = 8,
   parameter off_mode_e OFF_MODE = OFF_ZERO
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_n,
   input  logic             ser_in,
   input  logic             shift_en,
   input  logic             store_en,
   input  logic             oe_n,
   output logic [WIDTH-1:0] par_data,
   output logic             par_valid,
   output logic             ser_out
);
   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("sipo_latch_reg: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] stages;
   logic [WIDTH-1:0] latch_q;

   sipo_shift_chain #(.WIDTH(WIDTH)) chain_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_n    (clr_n),
      .shift_en (shift_en),
      .ser_in   (ser_in),
      .stages   (stages)
   );

   sipo_store_reg #(.WIDTH(WIDTH)) latch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .store_en (store_en),
      .d        (stages),
      .q        (latch_q)
   );

   sipo_out_drive #(.WIDTH(WIDTH), .OFF_MODE(OFF_MODE)) drive_i (
      .oe_n    (oe_n),
      .latch_q (latch_q),
      .data    (par_data),
      .valid   (par_valid)
   );

   assign ser_out = stages[TOP];

   // R3: serial tap follows the stage below it after each shift
   assert_serout_R3: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      shift_en |=> (ser_out == $past(stages[TOP-1])));

   // R5: latch sees the chain from before a coincident shift
   assert_lag_R5: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      (shift_en && store_en) |=> (latch_q == $past(stages)));

   // R7: store during clear captures zero
   assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_n && store_en) |=> (latch_q == '0));

   // R8: enabled bus reflects the latch
   assert_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (par_valid && (par_data == latch_q)));

   // R6: clear leaves the latch untouched
   assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_n && !store_en) |=> $stable(latch_q));
endmodule

// File: tb/sipo_latch_reg_tb_top.sv
module sipo_latch_reg_tb_top;
   localparam int W = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, clr_n, ser_in, shift_en, store_en, oe_n;
   logic [W-1:0] near_data, far_data;
   logic near_valid, far_valid, near_so, far_so;

   sipo_latch_reg #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ser_in(ser_in),
      .shift_en(shift_en), .store_en(store_en), .oe_n(oe_n),
      .par_data(near_data), .par_valid(near_valid), .ser_out(near_so));

   sipo_latch_reg #(.WIDTH(W)) dut_far_i (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ser_in(near_so),
      .shift_en(shift_en), .store_en(store_en), .oe_n(oe_n),
      .par_data(far_data), .par_valid(far_valid), .ser_out(far_so));

   int vectors = 0;
   int errors  = 0;
   logic [15:0] m_chain;   // [7:0] near stages, [15:8] far stages
   logic [15:0] m_store;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] exp_bus(input logic oe, input logic [15:0] st);
      return oe ? 16'h0000 : st;
   endfunction

   task automatic check_all(input string tag);
      chk({tag, " data"},  {far_data, near_data}, exp_bus(oe_n, m_store));
      chk({tag, " valid"}, {14'b0, far_valid, near_valid}, {14'b0, !oe_n, !oe_n});
      chk({tag, " serial"}, {14'b0, far_so, near_so}, {14'b0, m_chain[15], m_chain[7]});
   endtask

   task automatic step(input logic si, input logic sh, input logic st,
                       input logic cl, input logic oe);
      @(negedge clk);
      ser_in = si; shift_en = sh; store_en = st; clr_n = cl; oe_n = oe;
      if (!cl) m_chain = '0;
      @(posedge clk);
      if (st) m_store = m_chain;                   // store sees pre-shift chain
      if (sh && cl) m_chain = {m_chain[14:0], si};
      #5;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; m_chain = '0; m_store = '0;
      #1 check_all("R1 reset");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(64'd20 * 64'd200000);
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [15:0] pat;
      void'($urandom(32'd4711));
      rst_n = 1'b0; clr_n = 1'b1; ser_in = 1'b0; shift_en = 1'b0;
      store_en = 1'b0; oe_n = 1'b0;
      m_chain = '0; m_store = '0;
      repeat (2) @(posedge clk);
      do_reset();

      // R2/R3: shift a directed byte, serial tap watched every step
      for (int i = 7; i >= 0; i--) begin
         step(pat_bit(8'b1011_0010, i), 1'b1, 1'b0, 1'b1, 1'b0);
         check_all("R2 R3 shift");
      end
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0); check_all("R2 hold");
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0); check_all("R4 store");
      chk("R4 near word", {8'h00, near_data}, 16'h00B2);
      step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0); check_all("R4 latch holds");

      // R5: coincident shift and store
      step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0); check_all("R5 same edge");

      // R6: clear between shifts keeps the latch
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
      step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      clr_n = 1'b0; shift_en = 1'b0; store_en = 1'b0; m_chain = '0;
      #1 check_all("R6 async clear");
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0); check_all("R6 shift ignored");
      step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0); check_all("R6 released");

      // R7: store during clear
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0); check_all("R7 zero store");
      chk("R7 word", {far_data, near_data}, 16'h0000);

      // R8: output enable
      for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1); check_all("R8 disabled");
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1); check_all("R8 serial unaffected");
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0); check_all("R8 re-enabled");

      // R9: 16-bit cascade, first bit ends on far MSB
      pat = 16'hA5C3;
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int i = 15; i >= 0; i--) step(pat[i], 1'b1, 1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      chk("R9 cascade", {far_data, near_data}, pat);
      check_all("R9 model");

      // R1: reset after activity
      do_reset();

      // Random mix covering R2 R4 R5 R6 R7 R8
      for (int n = 0; n < 500; n++) begin
         step(1'($urandom % 2), 1'(($urandom % 4) != 0), 1'(($urandom % 5) == 0),
              1'(($urandom % 16) != 0), 1'(($urandom % 6) == 0));
         check_all("R2 R4 R5 random");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   function automatic logic pat_bit(input logic [7:0] v, input int i);
      return v[i];
   endfunction
endmodule